// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a clocked static memory with a two-bit burst address generator. All inputs are taken at the rising clock edge. The 16-bit word is split into two byte lanes that can be written separately. A burst is opened by one of two address strobes. The processor-side strobe has no effect while the primary select is inactive. The controller-side strobe always takes effect. Either strobe loads the full address and clears the burst count. After that, each cycle with the advance input active moves the two low address bits one step. A mode pin picks the order of those steps: linear (start plus count, wrapping at four) or interleaved (start XOR count).

Read data goes through a two-stage pipeline made of a synchronous array read and an output register. A separate flag marks the cycles in which the data bus is actively driven. That flag drops whenever output-enable is inactive or no read is in flight. A sleep input freezes the block while keeping the array contents. After sleep is released, accesses stay blocked for a fixed recovery count of cycles.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held, and after it until a strobe selects the device, `rdata_drive` is 0.
- R2: A read issued on the cycle ending at edge N shows on `rdata` with `rdata_drive` high after edge N+1, and not after edge N.
- R3: With `wr_all_n` high and `wr_byte_n` low, `byte_sel_n[0]` low writes bits 7:0 and `byte_sel_n[1]` low writes bits 15:8; a low `wr_all_n` writes both lanes whatever the byte controls are.
- R4: With `order_ilv` = 0, the low two address bits of the k-th burst access are (start + k) mod 4. The high bits stay at the strobed address.
- R5: With `order_ilv` = 1, the low two address bits of the k-th burst access are start XOR k.
- R6: A low `strb_cpu_n` while `sel_n` is high is ignored: the running burst address is kept.
- R7: `sel_hi` (active high) and `sel_lo_n` (active low) take effect only on strobe cycles. A controller strobe with `sel_n` high, `sel_hi` low or `sel_lo_n` high deselects the device, and `rdata_drive` stays 0 until a later strobe selects it.
- R8: The cycle that takes a processor strobe never writes. A write on the next cycle, with `step_n` high, goes to the strobed address.
- R9: `out_en_n` high forces `rdata_drive` low in the same cycle.
- R10: A selected cycle with no strobe and `step_n` high keeps the current burst address.
- R11: On a cycle with `sleep` high, no read or write happens, the array keeps its contents and `rdata_drive` is 0 after that edge. Accesses stay blocked for RECOV_CYC edges after the first edge that samples `sleep` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, loaded on strobe cycles |
| din | input | 16 | Write data |
| strb_cpu_n | input | 1 | Processor-side address strobe, masked by `sel_n` |
| strb_cache_n | input | 1 | Controller-side address strobe, never masked |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of both lanes, active low |
| wr_byte_n | input | 1 | Enables the per-lane write selects, active low |
| byte_sel_n | input | 2 | Lane write selects, bit 0 for 7:0, bit 1 for 15:8 |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| out_en_n | input | 1 | Output enable, active low, not registered |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Retention sleep request |
| rdata | output | 16 | Registered read data |
| rdata_drive | output | 1 | High when the data bus would be driven |

## Verification
The assertions assume that `rst`, `sleep` and every strobe and select input are already settled to 0 or 1 when an edge samples them. They also assume `order_ilv` does not change in the middle of a burst. The bench changes inputs only on the falling edge, and it keeps `order_ilv` fixed from each strobe until the last step of that burst. It always drives `sel_n`, `sel_hi` and `sel_lo_n` to defined values, including on the idle cycles used to show that those pins are ignored.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;

  // next low address bits for burst step n
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ n;
    else     r = start + n;
    return r;
  endfunction
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_stb,
  input  logic              cache_stb,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              step_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_sel
);
  import sbs_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nx;
  logic              sel_q, any_stb, stb_sel;
  logic [ADDR_W-1:0] start_addr;

  always_comb begin
    any_stb    = cpu_stb | cache_stb;
    // processor strobe only reaches here with the primary select active
    stb_sel    = cpu_stb ? (sel_hi & ~sel_lo_n)
                         : (~sel_n & sel_hi & ~sel_lo_n);
    acc_sel    = any_stb ? stb_sel : sel_q;
    start_addr = any_stb ? addr : base_q;
    if (any_stb)               cnt_nx = 2'd0;
    else if (sel_q && !step_n) cnt_nx = cnt_q + 2'd1;
    else                       cnt_nx = cnt_q;
    acc_addr = {start_addr[ADDR_W-1:2], burst_lo(start_addr[1:0], cnt_nx, order_ilv)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      sel_q  <= 1'b0;
    end else if (!hold) begin
      if (any_stb) base_q <= addr;
      cnt_q <= cnt_nx;
      sel_q <= acc_sel;
    end
  end
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         we,
  input  logic                     re,
  input  logic [LANES*LANE_W-1:0]  wd,
  output logic [LANES*LANE_W-1:0]  rd
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wd[g*LANE_W +: LANE_W];
      if (re)    rd[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/sbs_doze.sv
module sbs_doze #(
  parameter int unsigned RECOV_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  output logic busy
);
  localparam int unsigned RW = $clog2(RECOV_CYC + 1);
  localparam logic [RW-1:0] RELOAD = RW'(RECOV_CYC);

  logic [RW-1:0] rec_q;

  always_ff @(posedge clk) begin
    if (rst)              rec_q <= '0;
    else if (sleep)       rec_q <= RELOAD;
    else if (rec_q != '0) rec_q <= rec_q - 1'b1;
  end

  assign busy = sleep | (rec_q != '0);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  input  logic              strb_cpu_n,
  input  logic              strb_cache_n,
  input  logic              step_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [1:0]        byte_sel_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              out_en_n,
  input  logic              order_ilv,
  input  logic              sleep,
  output logic [15:0]       rdata,
  output logic              rdata_drive
);
  import sbs_pkg::*;

  logic              blocked, cpu_stb, cache_stb, acc_sel, rd_en;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_mask, we_bytes;
  logic [15:0]       ram_q;
  logic              rv1_q, rv2_q;

  sbs_doze #(.RECOV_CYC(RECOV_CYC)) u_doze (
    .clk(clk), .rst(rst), .sleep(sleep), .busy(blocked)
  );

  assign cpu_stb   = ~strb_cpu_n & ~sel_n & ~blocked;
  assign cache_stb = ~strb_cache_n & ~blocked;

  sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .hold(blocked), .addr(addr),
    .cpu_stb(cpu_stb), .cache_stb(cache_stb),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .step_n(step_n), .order_ilv(order_ilv),
    .acc_addr(acc_addr), .acc_sel(acc_sel)
  );

  always_comb begin
    if (!wr_all_n)      lane_mask = '1;
    else if (!wr_byte_n) lane_mask = ~byte_sel_n;
    else                lane_mask = '0;
    we_bytes = (acc_sel && !blocked && !cpu_stb) ? lane_mask : '0;
    rd_en    = acc_sel && !blocked && (we_bytes == '0);
  end

  sbs_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_ram (
    .clk(clk), .addr(acc_addr), .we(we_bytes), .re(rd_en),
    .wd(din), .rd(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1_q <= 1'b0;
      rv2_q <= 1'b0;
      rdata <= '0;
    end else begin
      rv1_q <= rd_en;
      rv2_q <= rv1_q & ~blocked;
      if (rv1_q) rdata <= ram_q;
    end
  end

  assign rdata_drive = rv2_q & ~out_en_n;
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk (
  input logic       clk,
  input logic       rst,
  input logic       strb_cpu_n,
  input logic       strb_cache_n,
  input logic       sel_n,
  input logic       out_en_n,
  input logic       sleep,
  input logic       blocked,
  input logic [1:0] we_bytes,
  input logic       rdata_drive
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rdata_drive);

  // R7
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb_cache_n && sel_n && !blocked) |=> ##1 !rdata_drive);

  // R8
  cpu_strobe_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && !sel_n && !blocked) |-> (we_bytes == 2'b00));

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !rdata_drive);

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !rdata_drive);

  // R11
  sleep_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (we_bytes == 2'b00));
endmodule

bind sync_burst_sram sbs_chk u_chk (
  .clk(clk), .rst(rst), .strb_cpu_n(strb_cpu_n), .strb_cache_n(strb_cache_n),
  .sel_n(sel_n), .out_en_n(out_en_n), .sleep(sleep), .blocked(blocked),
  .we_bytes(we_bytes), .rdata_drive(rdata_drive)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int unsigned AW = 8;
  localparam int unsigned RC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0;
  logic strb_cpu_n = 1'b1, strb_cache_n = 1'b1, step_n = 1'b1;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [1:0] byte_sel_n = 2'b11;
  logic sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic out_en_n = 1'b0, order_ilv = 1'b0, sleep = 1'b0;
  logic [15:0] rdata;
  logic rdata_drive;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .RECOV_CYC(RC)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .strb_cpu_n(strb_cpu_n), .strb_cache_n(strb_cache_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .out_en_n(out_en_n), .order_ilv(order_ilv), .sleep(sleep),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    strb_cpu_n = 1'b1; strb_cache_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = 2'b11; din = '0;
  endtask

  task automatic sel_ok();
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    idle(); sel_ok(); strb_cache_n = 1'b0; addr = a; din = d; wr_all_n = 1'b0;
    tick(); idle();
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    idle(); sel_ok(); strb_cache_n = 1'b0; addr = a;
    tick(); idle(); tick();
    chk({tag, " drive"}, rdata_drive, 1);
    chk({tag, " data"}, rdata, exp);
  endtask

  task automatic t_reset();
    chk("R1 drive during reset", rdata_drive, 0);
    repeat (3) tick();
    rst = 1'b0;
    tick(); tick();
    chk("R1 drive after reset", rdata_drive, 0);
  endtask

  task automatic t_latency();
    wr(8'h10, 16'hA5A5);
    sel_ok(); strb_cache_n = 1'b0; addr = 8'h10;
    tick(); idle();
    chk("R2 not yet driven", rdata_drive, 0);
    tick();
    chk("R2 driven", rdata_drive, 1);
    chk("R2 data", rdata, 16'hA5A5);
  endtask

  task automatic t_bytes();
    wr(8'h20, 16'h1111);
    sel_ok(); strb_cache_n = 1'b0; addr = 8'h20; din = 16'hCDAB;
    wr_byte_n = 1'b0; byte_sel_n = 2'b10; tick(); idle();
    rd_chk(8'h20, 16'h11AB, "R3 low lane");
    sel_ok(); strb_cache_n = 1'b0; addr = 8'h20; din = 16'hEF00;
    wr_byte_n = 1'b0; byte_sel_n = 2'b01; tick(); idle();
    rd_chk(8'h20, 16'hEFAB, "R3 high lane");
    sel_ok(); strb_cache_n = 1'b0; addr = 8'h20; din = 16'h7777;
    wr_all_n = 1'b0; wr_byte_n = 1'b1; byte_sel_n = 2'b11; tick(); idle();
    rd_chk(8'h20, 16'h7777, "R3 global write");
  endtask

  task automatic burst(input logic [AW-1:0] start, input logic ilv,
                       input logic [1:0] o1, input logic [1:0] o2,
                       input logic [1:0] o3, input string tag);
    logic [1:0] seq [4];
    seq[0] = start[1:0]; seq[1] = o1; seq[2] = o2; seq[3] = o3;
    order_ilv = ilv;
    idle(); sel_ok(); strb_cache_n = 1'b0; addr = start;
    tick(); idle();
    for (int k = 0; k < 3; k++) begin
      step_n = 1'b0; tick();
      chk(tag, rdata, {14'h0C00, seq[k]});
    end
    step_n = 1'b1; tick();
    chk(tag, rdata, {14'h0C00, seq[3]});
    tick();
    chk("R10 suspend holds address", rdata, {14'h0C00, seq[3]});
    order_ilv = 1'b0;
  endtask

  task automatic t_orders();
    for (int i = 0; i < 4; i++) wr(AW'(8'h30 + i), 16'h3000 + 16'(i));
    burst(8'h32, 1'b0, 2'd3, 2'd0, 2'd1, "R4 linear order");
    burst(8'h31, 1'b1, 2'd0, 2'd3, 2'd2, "R5 interleaved order");
  endtask

  task automatic t_mask();
    idle(); sel_ok(); strb_cache_n = 1'b0; addr = 8'h30; tick(); idle();
    step_n = 1'b0; tick(); idle();
    sel_n = 1'b1; strb_cpu_n = 1'b0; addr = 8'h33; tick(); idle(); sel_ok();
    tick();
    chk("R6 masked strobe keeps burst", rdata, 16'h3001);
  endtask

  task automatic t_select();
    idle(); sel_n = 1'b0; sel_hi = 1'b0; sel_lo_n = 1'b0;
    strb_cache_n = 1'b0; addr = 8'h30; tick(); idle();
    tick(); tick();
    chk("R7 deselected", rdata_drive, 0);
    sel_hi = 1'b1; tick(); tick();
    chk("R7 select ignored off strobe", rdata_drive, 0);
    strb_cpu_n = 1'b0; addr = 8'h31; tick(); idle();
    sel_hi = 1'b0; tick();
    chk("R7 reselected drive", rdata_drive, 1);
    chk("R7 reselected data", rdata, 16'h3001);
    tick();
    chk("R7 select kept", rdata_drive, 1);
    sel_ok();
  endtask

  task automatic t_cpu_write();
    wr(8'h40, 16'h1234);
    sel_ok(); strb_cpu_n = 1'b0; addr = 8'h40; wr_all_n = 1'b0; din = 16'hDEAD;
    tick(); idle(); tick();
    rd_chk(8'h40, 16'h1234, "R8 strobe cycle no write");
    sel_ok(); strb_cpu_n = 1'b0; addr = 8'h40; tick(); idle();
    wr_all_n = 1'b0; din = 16'hBEEF; tick(); idle();
    rd_chk(8'h40, 16'hBEEF, "R8 follow-up write");
  endtask

  task automatic t_oe();
    rd_chk(8'h10, 16'hA5A5, "R9 baseline");
    out_en_n = 1'b1; #1;
    chk("R9 output disabled", rdata_drive, 0);
    out_en_n = 1'b0; #1;
    chk("R9 output re-enabled", rdata_drive, 1);
  endtask

  task automatic t_sleep();
    wr(8'h50, 16'h5555);
    rd_chk(8'h50, 16'h5555, "R11 pre-sleep");
    sleep = 1'b1; sel_ok(); strb_cache_n = 1'b0; addr = 8'h50;
    wr_all_n = 1'b0; din = 16'hAAAA;
    tick(); idle();
    chk("R11 quiet in sleep", rdata_drive, 0);
    tick();
    sleep = 1'b0; strb_cache_n = 1'b0; addr = 8'h50; wr_all_n = 1'b0; din = 16'h9999;
    tick(); idle();
    repeat (RC - 1) tick();
    chk("R11 quiet in recovery", rdata_drive, 0);
    rd_chk(8'h50, 16'h5555, "R11 retained");
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick();
    t_reset();
    t_latency();
    t_bytes();
    t_orders();
    t_mask();
    t_select();
    t_cpu_write();
    t_oe();
    t_sleep();
    finish_run();
  end
endmodule